// File: doc/BRIEF.md
# Binary-Search Delay-Locked Loop Controller

This block is the digital control core of an all-digital delay-locked loop. After reset it measures the reference clock period in units of one delay cell by running a successive-approximation search over a digitally controlled measurement delay line. An external phase comparator returns one bit per trial. It reports whether the delayed edge lags the reference. The search settles one code bit per clock, starting from the most significant bit.

When the period code is final, the controller works out a per-tap delay code for each cell of a separate multi-tap output delay line. The taps share the period evenly, so their codes add up to exactly the measured period and the taps give evenly spaced phases across one reference cycle. The controller then raises a registered lock flag. If the search ends at either end of the code range, the period cannot be represented. In that case an out-of-range flag is raised instead of lock. The delay cells and the phase comparator are outside this block.

Top module: `dll_ctrl_top`

## Requirements
- R1: While reset is high and on the first clock after it falls, `locked` and `range_err` are 0, `meas_code` is 0 and every tap code is 0.
- R2: On the first rising edge after reset is released, `meas_code` becomes the value with only its most significant bit set (64 for the default 7-bit code).
- R3: On each following edge, `late` is sampled against the code applied on the previous edge. A high value clears the bit under trial, and the next lower bit is then set to 1. Only one bit is decided per cycle.
- R4: Suppose the comparator reports late exactly when `meas_code` exceeds the period P in cell units. Then the final `meas_code` equals min(P, 2^CODE_W-1).
- R5: A flag (`locked` or `range_err`) goes high on the CODE_W+2-th rising edge after reset release, which is edge 9 for the default. Both flags stay low on every earlier edge.
- R6: Tap i, held in bits [i*TAP_W +: TAP_W] of `tap_codes`, equals floor((i+1)*P/N_TAPS) - floor(i*P/N_TAPS), where P is the final `meas_code`.
- R7: While `locked` is high, the tap codes add up to exactly `meas_code`, and each tap equals floor(P/N_TAPS) or that value plus 1.
- R8: If the final code is all zeros or all ones, `range_err` rises instead of `locked`, and the tap codes stay 0.
- R9: `locked` and `range_err` are never high together.
- R10: After a flag has risen, `late` has no effect. `meas_code`, `tap_codes` and the flags hold until the next reset.
- R11: Asserting reset during the search clears the block, and a complete new acquisition follows its release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| late | input | 1 | Comparator result: 1 when the delayed edge lags the reference |
| meas_code | output | CODE_W | Code applied to the measurement delay line |
| tap_codes | output | N_TAPS*TAP_W | Per-tap codes for the output delay line, tap 0 in the low bits |
| locked | output | 1 | Acquisition finished with an in-range period |
| range_err | output | 1 | Acquisition finished at a code-range limit |

## Verification
The checker assumes that `late` is a clean bit sampled on the clock edge. It also assumes that reset is released synchronously, so the cycle count since release is exact. It makes no assumption about whether the comparator answers agree with each other. The bench drives `late` from a behavioural comparator that reads `meas_code` and compares it with a chosen period. That period ranges from zero up to beyond the code range, including values that land on rounding boundaries. The bench changes `late` only on falling edges, and it drives random comparator noise only after a flag has risen.

// File: rtl/dll_pkg.sv
package dll_pkg;
  typedef enum logic [1:0] {
    SAR_START = 2'd0,
    SAR_TRY   = 2'd1,
    SAR_DONE  = 2'd2
  } sar_state_t;
endpackage

// File: rtl/dll_sar.sv
module dll_sar #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              late,
  output logic [CODE_W-1:0] code,
  output logic              done
);
  import dll_pkg::*;
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

  sar_state_t        st;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  idx_m1;
  logic [CODE_W-1:0] nxt;

  assign idx_m1 = idx - 1'b1;

  always_comb begin
    nxt = code;
    if (late) nxt[idx] = 1'b0;
    if (idx != '0) nxt[idx_m1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SAR_START;
      code <= '0;
      idx  <= IDX_W'(CODE_W - 1);
    end else begin
      case (st)
        SAR_START: begin
          code <= {1'b1, {(CODE_W-1){1'b0}}};
          st   <= SAR_TRY;
        end
        SAR_TRY: begin
          code <= nxt;
          if (idx == '0) st <= SAR_DONE;
          else           idx <= idx_m1;
        end
        default: st <= SAR_DONE;
      endcase
    end
  end

  assign done = (st == SAR_DONE);
endmodule

// File: rtl/dll_tap_map.sv
module dll_tap_map #(
  parameter int CODE_W = 7,
  parameter int N_TAPS = 32,
  parameter int TAP_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [CODE_W-1:0]       code,
  output logic [N_TAPS*TAP_W-1:0] taps
);
  localparam int SH     = $clog2(N_TAPS);
  localparam int PROD_W = CODE_W + SH + 1;

  logic [N_TAPS*TAP_W-1:0] taps_d;

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    logic [PROD_W-1:0] lo_prod, hi_prod, lo_q, hi_q;
    assign lo_prod = PROD_W'(code) * PROD_W'(i);
    assign hi_prod = PROD_W'(code) * PROD_W'(i + 1);
    assign lo_q    = lo_prod >> SH;
    assign hi_q    = hi_prod >> SH;
    assign taps_d[i*TAP_W +: TAP_W] = TAP_W'(hi_q - lo_q);
  end

  always_ff @(posedge clk) begin
    if (rst)       taps <= '0;
    else if (load) taps <= taps_d;
  end
endmodule

// File: rtl/dll_ctrl_top.sv
module dll_ctrl_top #(
  parameter int CODE_W = 7,
  parameter int N_TAPS = 32,
  parameter int TAP_W  = CODE_W - $clog2(N_TAPS) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    late,
  output logic [CODE_W-1:0]       meas_code,
  output logic [N_TAPS*TAP_W-1:0] tap_codes,
  output logic                    locked,
  output logic                    range_err
);
  logic sar_done;
  logic fin;
  logic at_edge;
  logic take;

  dll_sar #(.CODE_W(CODE_W)) u_sar (
    .clk  (clk),
    .rst  (rst),
    .late (late),
    .code (meas_code),
    .done (sar_done)
  );

  assign at_edge = (meas_code == '0) || (meas_code == '1);
  assign take    = sar_done && !fin;

  dll_tap_map #(.CODE_W(CODE_W), .N_TAPS(N_TAPS), .TAP_W(TAP_W)) u_map (
    .clk  (clk),
    .rst  (rst),
    .load (take && !at_edge),
    .code (meas_code),
    .taps (tap_codes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fin       <= 1'b0;
      locked    <= 1'b0;
      range_err <= 1'b0;
    end else if (take) begin
      fin       <= 1'b1;
      locked    <= !at_edge;
      range_err <= at_edge;
    end
  end
endmodule

// File: rtl/dll_ctrl_chk.sv
module dll_ctrl_chk #(
  parameter int CODE_W = 7,
  parameter int N_TAPS = 32,
  parameter int TAP_W  = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic [CODE_W-1:0]       meas_code,
  input logic [N_TAPS*TAP_W-1:0] tap_codes,
  input logic                    locked,
  input logic                    range_err
);
  localparam int SH      = $clog2(N_TAPS);
  localparam int CNT_W   = $clog2(CODE_W + 4) + 1;
  localparam int LOCK_AT = CODE_W + 2;
  localparam int SUM_W   = CODE_W + SH + 1;

  logic [CNT_W-1:0] cyc;
  logic [SUM_W-1:0] tap_sum;
  logic             tap_spread_ok;
  logic [CODE_W-1:0] base;

  always_ff @(posedge clk) begin
    if (rst)                     cyc <= '0;
    else if (cyc != CNT_W'(LOCK_AT)) cyc <= cyc + 1'b1;
  end

  assign base = meas_code >> SH;

  always_comb begin
    tap_sum       = '0;
    tap_spread_ok = 1'b1;
    for (int i = 0; i < N_TAPS; i++) begin
      tap_sum = tap_sum + SUM_W'(tap_codes[i*TAP_W +: TAP_W]);
      if ((CODE_W'(tap_codes[i*TAP_W +: TAP_W]) != base) &&
          (CODE_W'(tap_codes[i*TAP_W +: TAP_W]) != base + 1'b1))
        tap_spread_ok = 1'b0;
    end
  end

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(locked && range_err));

  // R5
  flag_deadline_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CNT_W'(LOCK_AT)) |-> (locked || range_err));

  // R5
  no_early_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc < CNT_W'(LOCK_AT)) |-> !(locked || range_err));

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> (locked && $stable(meas_code) && $stable(tap_codes)));

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    range_err |=> (range_err && $stable(meas_code)));

  // R7
  tap_sum_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> (tap_sum == SUM_W'(meas_code)));

  // R7
  tap_spread_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> tap_spread_ok);

  // R8
  err_taps_zero_chk: assert property (@(posedge clk) disable iff (rst)
    range_err |-> (tap_codes == '0));
endmodule

bind dll_ctrl_top dll_ctrl_chk #(.CODE_W(CODE_W), .N_TAPS(N_TAPS), .TAP_W(TAP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .meas_code (meas_code),
  .tap_codes (tap_codes),
  .locked    (locked),
  .range_err (range_err)
);

// File: tb/test_dll_ctrl_top.sv
module test_dll_ctrl_top;
  localparam int CODE_W = 7;
  localparam int N_TAPS = 32;
  localparam int TAP_W  = CODE_W - $clog2(N_TAPS) + 1;
  localparam int MAXC   = (1 << CODE_W) - 1;
  localparam int LOCK_AT = CODE_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic late;
  logic [CODE_W-1:0]       meas_code;
  logic [N_TAPS*TAP_W-1:0] tap_codes;
  logic locked, range_err;

  int period = 0;
  logic noise_en = 1'b0;
  logic noise_bit = 1'b0;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  assign late = noise_en ? noise_bit : (int'(meas_code) > period);

  dll_ctrl_top #(.CODE_W(CODE_W), .N_TAPS(N_TAPS)) i_dll_ctrl_top (
    .clk(clk), .rst(rst), .late(late),
    .meas_code(meas_code), .tap_codes(tap_codes),
    .locked(locked), .range_err(range_err)
  );

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic start_reset();
    @(negedge clk);
    rst = 1'b1; noise_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int exp_tap(input int p, input int i);
    return ((i + 1) * p) / N_TAPS - (i * p) / N_TAPS;
  endfunction

  // Full acquisition for period p; covers R2 R3 R4 R5 R6 R8.
  task automatic run_case(input int p);
    int fin;
    int in_range;
    period = p;
    start_reset();
    fin = (p > MAXC) ? MAXC : p;
    in_range = (fin != 0 && fin != MAXC);
    for (int e = 1; e <= LOCK_AT; e++) begin
      @(negedge clk);
      if (e == 1) check("R2", int'(meas_code), 1 << (CODE_W - 1));
      if (e == 2) check("R3", int'(meas_code),
                        ((p >= (1 << (CODE_W-1))) ? (1 << (CODE_W-1)) : 0) | (1 << (CODE_W-2)));
      if (e < LOCK_AT) check("R5", int'(locked | range_err), 0);
    end
    check("R4", int'(meas_code), fin);
    check("R5", int'(locked), in_range);
    check("R8", int'(range_err), in_range ? 0 : 1);
    for (int i = 0; i < N_TAPS; i++)
      check(in_range ? "R6" : "R8", int'(tap_codes[i*TAP_W +: TAP_W]),
            in_range ? exp_tap(fin, i) : 0);
    if (in_range) begin
      int s = 0;
      for (int i = 0; i < N_TAPS; i++) s += int'(tap_codes[i*TAP_W +: TAP_W]);
      check("R7", s, fin);
    end
  endtask

  task automatic test_reset_state();
    period = 50;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", int'(meas_code), 0);
    check("R1", int'(locked), 0);
    check("R1", int'(range_err), 0);
    check("R1", int'(tap_codes != '0), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(locked | range_err), 0);
  endtask

  task automatic test_hold_after_lock();
    logic [CODE_W-1:0] c0;
    logic [N_TAPS*TAP_W-1:0] t0;
    run_case(77);
    c0 = meas_code; t0 = tap_codes;
    noise_en = 1'b1;
    for (int k = 0; k < 20; k++) begin
      noise_bit = k[0] ^ k[2];
      @(negedge clk);
    end
    noise_en = 1'b0;
    check("R10", int'(meas_code), int'(c0));
    check("R10", int'(tap_codes == t0), 1);
    check("R10", int'(locked), 1);
    check("R9", int'(locked & range_err), 0);
  endtask

  task automatic test_mid_reset();
    period = 20;
    start_reset();
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11", int'(meas_code), 0);
    check("R11", int'(locked | range_err), 0);
    run_case(100);
    check("R11", int'(meas_code), 100);
  endtask

  initial begin
    fork
      begin
        test_reset_state();
        run_case(64);
        run_case(25);
        run_case(31);
        run_case(33);
        run_case(126);
        run_case(1);
        run_case(0);
        run_case(127);
        run_case(300);
        test_hold_after_lock();
        test_mid_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule